// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Level Event

This block is the receive-side byte store of a two-wire serial bus controller. The shift engine writes each received byte into a sixteen-entry first-in first-out queue. A register-mapped host drains the queue one byte per read of the data port. Alongside the data port the host sees three values. The first is an occupancy code. The second is a status byte carrying the empty and full flags. The third is a level register that it programs itself.

Both the occupancy code and the level register count from zero. The occupancy code reads one less than the number of bytes held. A level value of N makes the level event assert once N+1 bytes are waiting. The host can rewrite the level between bursts so that the event fires exactly when the remaining bytes of a message have arrived. The event is a plain level signal. Latching it into an interrupt is left to the surrounding controller.

Top module: `rxq_watermark_fifo`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) produces the following state: the queue is empty, occ_code is 0, status_flags is 8'h40, overflow_flag is 0, wm_value is 15 (DEPTH-1) and rd_byte is 0.
- R2: Bytes leave in the order they were accepted. A host_pop on a non-empty queue places the oldest byte on rd_byte after the same clock edge, and that byte is removed from the queue.
- R3: The queue holds at most 16 bytes (DEPTH). status_flags bit 5 is 1 exactly when 16 bytes are stored.
- R4: When the queue is full, an in_valid without a host_pop in the same cycle is dropped and the stored bytes are unchanged. overflow_flag then goes to 1 and stays at 1 until reset.
- R5: A host_pop on an empty queue leaves rd_byte at its previous value and leaves the queue empty.
- R6: occ_code reads the number of stored bytes minus one. It reads 0 when the queue is empty.
- R7: wm_value is zero-based. With a value of N, rx_level_event is 1 exactly while the stored count is at least N+1.
- R8: A wm_we write loads wm_wdata at the clock edge. It may happen at any time, and rx_level_event is re-evaluated against the current count from the next cycle.
- R9: status_flags bit 6 is 1 exactly when the queue is empty. All status_flags bits other than 5 and 6 read 0.
- R10: When an accepted push and a pop of a non-empty queue happen in the same cycle, the count is unchanged. This includes the full case: the oldest byte is returned and the new byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Shift engine presents a received byte |
| in_byte | input | 8 | Received byte |
| host_pop | input | 1 | Host read of the data port, removes one byte |
| rd_byte | output | 8 | Byte returned by the latest successful pop |
| wm_we | input | 1 | Write strobe for the level register |
| wm_wdata | input | 4 | Zero-based level value |
| wm_value | output | 4 | Current level register contents |
| occ_code | output | 4 | Stored count minus one (0 when empty) |
| status_flags | output | 8 | Bit 6 empty, bit 5 full, other bits 0 |
| rx_level_event | output | 1 | Count has reached level+1 |
| overflow_flag | output | 1 | Sticky: a byte was dropped at full |

## Verification
The hardest situation to reach from the ports is a full queue that gets a push and a pop in the same cycle. The write and read pointers coincide there, so the drop decision has to take the pop into account. The stimulus reaches it in two ways. One is a directed fill to sixteen. The other is random phases biased heavily toward pushing, which keep the queue pinned at full while pops arrive at random. Level rewrites are mixed in at every fill level, so the event boundary is crossed both by count changes and by register writes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int STAT_W         = 8;
  localparam int STAT_EMPTY_BIT = 6;
  localparam int STAT_FULL_BIT  = 5;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } rxq_op_e;

  // zero-based occupancy readout: count-1, floored at zero
  function automatic int unsigned occ_readout(int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  // event rule for a zero-based level value
  function automatic logic level_reached(int unsigned n, int unsigned lvl);
    return (n >= lvl + 1);
  endfunction

  // level values beyond the last slot are held at the last slot
  function automatic int unsigned clamp_level(int unsigned v, int unsigned depth);
    return (v > depth - 1) ? depth - 1 : v;
  endfunction

endpackage

// File: rtl/rxq_occupancy.sv
module rxq_occupancy #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_fire,
  output logic          pop_fire,
  output logic [CW-1:0] count,
  output logic          is_empty,
  output logic          is_full,
  output logic          overflow
);
  import rxq_pkg::*;

  rxq_op_e op;

  assign is_empty  = (count == '0);
  assign is_full   = (count == CW'(DEPTH));
  assign pop_fire  = pop_req && !is_empty;
  assign push_fire = push_req && (!is_full || pop_fire);
  assign op        = rxq_op_e'({push_fire, pop_fire});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      case (op)
        OP_PUSH: count <= count + CW'(1);
        OP_POP:  count <= count - CW'(1);
        default: count <= count;
      endcase
      if (push_req && !push_fire) overflow <= 1'b1;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_drop_at_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && push_req && !pop_req) |=> (is_full && overflow));

  assert_sticky_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && pop_req && !push_req) |=> is_empty);

  assert_both_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && pop_fire) |=> $stable(count));

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_fire,
  input  logic [DW-1:0] push_data,
  input  logic          pop_fire,
  output logic [DW-1:0] pop_data
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW-1:0] wr_nxt, rd_nxt;

  generate
    if ((1 << PW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + PW'(1);
      assign rd_nxt = rd_ptr + PW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      pop_data <= '0;
    end else begin
      if (push_fire) wr_ptr <= wr_nxt;
      if (pop_fire) begin
        rd_ptr   <= rd_nxt;
        pop_data <= mem[rd_ptr];
      end
    end
  end

  assert_hold_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_fire |=> $stable(pop_data));

  assert_rd_still_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_fire |=> $stable(rd_ptr));

endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [PW-1:0] wdata,
  input  logic [CW-1:0] count,
  output logic [PW-1:0] level_q,
  output logic          hit
);
  import rxq_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= PW'(DEPTH - 1);
    else if (wr) level_q <= PW'(clamp_level(int'(wdata), DEPTH));
  end

  assign hit = level_reached(int'(count), int'(level_q));

  assert_hit_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (count != '0));

  assert_level_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(level_q));

endmodule

// File: rtl/rxq_watermark_fifo.sv
module rxq_watermark_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [DW-1:0]          in_byte,
  input  logic                   host_pop,
  output logic [DW-1:0]          rd_byte,
  input  logic                   wm_we,
  input  logic [PW-1:0]          wm_wdata,
  output logic [PW-1:0]          wm_value,
  output logic [PW-1:0]          occ_code,
  output logic [rxq_pkg::STAT_W-1:0] status_flags,
  output logic                   rx_level_event,
  output logic                   overflow_flag
);
  import rxq_pkg::*;

  logic          push_fire, pop_fire;
  logic [CW-1:0] count;
  logic          is_empty, is_full;

  rxq_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n),
    .push_req(in_valid), .pop_req(host_pop),
    .push_fire(push_fire), .pop_fire(pop_fire),
    .count(count), .is_empty(is_empty), .is_full(is_full),
    .overflow(overflow_flag)
  );

  rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_fire(push_fire), .push_data(in_byte),
    .pop_fire(pop_fire), .pop_data(rd_byte)
  );

  rxq_level #(.DEPTH(DEPTH)) u_lvl (
    .clk(clk), .rst_n(rst_n),
    .wr(wm_we), .wdata(wm_wdata), .count(count),
    .level_q(wm_value), .hit(rx_level_event)
  );

  assign occ_code = PW'(occ_readout(int'(count)));

  always_comb begin
    status_flags                 = '0;
    status_flags[STAT_EMPTY_BIT] = is_empty;
    status_flags[STAT_FULL_BIT]  = is_full;
  end

  assert_empty_occ_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_flags[STAT_EMPTY_BIT] |-> (occ_code == '0));

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status_flags) == 1 || (status_flags == '0));

  assert_full_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_flags[STAT_FULL_BIT] |-> rx_level_event);

endmodule

// File: tb/rxq_watermark_fifo_test.sv
module rxq_watermark_fifo_test;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, host_pop, wm_we;
  logic [7:0] in_byte;
  logic [3:0] wm_wdata;
  logic [7:0] rd_byte, status_flags;
  logic [3:0] wm_value, occ_code;
  logic       rx_level_event, overflow_flag;

  int unsigned total = 0, fails = 0;
  logic [7:0]  mq[$];
  int unsigned m_wm;
  logic [7:0]  m_pop;
  logic        m_ovf;

  always #10ns clk = ~clk;

  rxq_watermark_fifo uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .host_pop(host_pop), .rd_byte(rd_byte), .wm_we(wm_we), .wm_wdata(wm_wdata),
    .wm_value(wm_value), .occ_code(occ_code), .status_flags(status_flags),
    .rx_level_event(rx_level_event), .overflow_flag(overflow_flag)
  );

  function automatic int unsigned e_occ(int unsigned n);
    if (n > 0) return n - 1;
    return 0;
  endfunction

  function automatic logic [7:0] e_stat(int unsigned n);
    logic [7:0] s = 8'h00;
    if (n == 0) s = s | 8'h40;
    if (n == DEPTH) s = s | 8'h20;
    return s;
  endfunction

  function automatic logic e_hit(int unsigned n, int unsigned w);
    return n > w;
  endfunction

  task automatic chk(string tag, int unsigned act, int unsigned exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R6 occupancy", occ_code, e_occ(mq.size()));
    chk("R9/R3 status", status_flags, e_stat(mq.size()));
    chk("R7 level event", rx_level_event, e_hit(mq.size(), m_wm));
    chk("R4 overflow", overflow_flag, m_ovf);
    chk("R2 pop data", rd_byte, m_pop);
    chk("R8 level value", wm_value, m_wm);
  endtask

  task automatic step(logic p, logic [7:0] d, logic q, logic w, logic [3:0] wd);
    logic popped, acc;
    in_valid = p; in_byte = d; host_pop = q; wm_we = w; wm_wdata = wd;
    @(posedge clk);
    popped = q && (mq.size() > 0);
    acc = p && ((mq.size() < DEPTH) || popped);
    if (popped) m_pop = mq.pop_front();
    if (acc) mq.push_back(d);
    if (p && !acc) m_ovf = 1'b1;
    if (w) m_wm = wd;
    @(negedge clk);
    in_valid = 0; host_pop = 0; wm_we = 0;
    check_all();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk);
    mq.delete(); m_wm = DEPTH - 1; m_pop = 8'h00; m_ovf = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20ns * 200000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int unsigned pp, qp;
    logic [7:0] first;
    in_valid = 0; host_pop = 0; wm_we = 0; in_byte = 0; wm_wdata = 0; rst_n = 0;
    void'($urandom(32'h5eed));
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 occ after reset", occ_code, 0);
    chk("R1 status after reset", status_flags, 8'h40);
    chk("R1 overflow after reset", overflow_flag, 0);
    chk("R1 level after reset", wm_value, 15);
    chk("R1 rd_byte after reset", rd_byte, 0);

    // R7 boundary with level 3
    step(0, 0, 0, 1, 4'd3);
    for (int i = 0; i < 3; i++) step(1, 8'hA0 + 8'(i), 0, 0, 0);
    chk("R7 below level", rx_level_event, 0);
    step(1, 8'hA3, 0, 0, 0);
    chk("R7 at level", rx_level_event, 1);
    chk("R6 four stored", occ_code, 3);
    // R8 rewrite
    step(0, 0, 0, 1, 4'd1);
    chk("R8 lower level", rx_level_event, 1);
    step(0, 0, 0, 1, 4'd5);
    chk("R8 raise level", rx_level_event, 0);
    // R2 order
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 1, 0, 0);
      chk("R2 order", rd_byte, 8'hA0 + 8'(i));
    end
    // R5 pop from empty
    step(0, 0, 1, 0, 0);
    chk("R5 data held", rd_byte, 8'hA3);
    chk("R5 still empty", status_flags, 8'h40);

    // R3 fill to capacity
    for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + 8'(i), 0, 0, 0);
    chk("R3 full flag", status_flags, 8'h20);
    chk("R6 full occ", occ_code, 15);
    step(1, 8'hEE, 0, 0, 0);
    chk("R4 dropped", occ_code, 15);
    chk("R4 overflow set", overflow_flag, 1);
    // R10 push+pop at full
    step(1, 8'h77, 1, 0, 0);
    chk("R10 count held", occ_code, 15);
    chk("R10 oldest out", rd_byte, 8'h10);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 0);
    chk("R10 new byte kept last", rd_byte, 8'h77);
    chk("R4 sticky", overflow_flag, 1);

    // R7 level 0
    step(0, 0, 0, 1, 4'd0);
    step(1, 8'h55, 0, 0, 0);
    chk("R7 level zero one byte", rx_level_event, 1);

    // R1 reset with data present
    step(1, 8'h56, 0, 0, 0);
    do_reset();
    chk("R1 reset empties", status_flags, 8'h40);
    chk("R1 reset clears overflow", overflow_flag, 0);

    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      case (ph % 4)
        0: begin pp = 90; qp = 20; end
        1: begin pp = 50; qp = 50; end
        2: begin pp = 15; qp = 85; end
        default: begin pp = 95; qp = 60; end
      endcase
      for (int k = 0; k < 100; k++)
        step(($urandom % 100) < pp, 8'($urandom), ($urandom % 100) < qp,
             ($urandom % 16) == 0, 4'($urandom));
    end
    first = 8'h00;
    if (first == 8'h00) ;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule